// File: doc/BRIEF.md
# Tone Transceiver Host Register Interface

This block sits between a host microprocessor bus and the signalling core of a tone transceiver. One address line and active-low read and write strobes select one of four accesses: load the transmit digit, fetch the received digit, write a control register, or read status. Two 4-bit control registers share the control address. A select bit in the first register sends only the next control write to the second register. After that write, the pointer returns to the first register by itself.

The digit detector, the tone generator and the call-progress filter are outside this block and reach it through plain ports. These are a detected-digit strobe with a 4-bit code, a transmit-ready pulse, and a squared received-tone level. The combined active-low interrupt / call-progress pin reports digit and transmitter events in tone-digit mode. In call-progress mode it carries the synchronised tone waveform. In both modes the interrupt enable must be set.

The block is synchronous to `clk`. Every cycle in which a strobe combination is present counts as one access. Read data appears combinationally on `dout` during that cycle. State changes take effect at the clock edge that ends the access.

Top module: `tone_host_regs`

## Requirements
- R1: With `rs_sel`=0, `wr_n`=0 and `rd_n`=1, `din` is stored and shows on `tx_data` after the edge. If both strobes are low, or both are high, no register changes and `dout` is 0.
- R2: With `rs_sel`=0, `wr_n`=1 and `rd_n`=0, `dout` shows the last captured digit code. The edge that ends this access clears the receive-ready status flag.
- R3: A write to control register A stores its four bits: bit 0 tone enable, bit 1 mode (1 = call progress, 0 = tone digits), bit 2 interrupt enable, bit 3 select-next. `tone_en` equals bit 0.
- R4: A control write to A with bit 3 = 1 sends only the next control write to register B, which shows on `cfg_b`. The control write after that goes to A again. Bit 0 of B is burst enable.
- R5: A status read (`rs_sel`=1, `rd_n`=0, `wr_n`=1) returns bit 0 interrupt flag, bit 1 receive-ready, bit 2 transmit-ready, bit 3 delayed-steering. Its edge clears the interrupt, transmit-ready and delayed-steering flags. A new event in the same cycle sets its flag anyway.
- R6: In tone-digit mode a `dig_vld` cycle captures `dig_code` and sets receive-ready, delayed-steering and the interrupt flag. With interrupts enabled, `irq_cp_n` is low from the following edge until a status read clears the flag.
- R7: A `tx_req` pulse sets transmit-ready in any mode. It sets the interrupt flag only in tone-digit mode with burst enable on. A transmit data write clears transmit-ready, unless a pulse arrives in the same cycle.
- R8: In call-progress mode `dig_vld` is ignored: no capture and no flag change. With interrupts enabled, `irq_cp_n` equals `cp_tone` delayed by SYNC_STAGES clock edges.
- R9: With interrupt enable 0, `irq_cp_n` is 1 in every mode.
- R10: Reset clears both control registers, all flags and both data registers, and points the control address at A. After reset `tone_en`=0, `cfg_b`=0 and `irq_cp_n`=1.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous reset, active high |
| rs_sel | input | 1 | Address line: 0 data, 1 control/status |
| wr_n | input | 1 | Write strobe, active low |
| rd_n | input | 1 | Read strobe, active low |
| din | input | DW | Host write data |
| dout | output | DW | Host read data, 0 when not reading |
| dig_vld | input | 1 | Detected-digit strobe, one cycle per digit |
| dig_code | input | DW | Detected digit code |
| tx_req | input | 1 | Transmitter ready for more data |
| cp_tone | input | 1 | Squared received-tone level |
| tx_data | output | DW | Transmit digit register |
| tone_en | output | 1 | Tone output enable |
| cfg_b | output | DW | Control register B contents |
| irq_cp_n | output | 1 | Interrupt (active low) or call-progress waveform |

## Verification
A read result on `dout` is due in the access cycle itself, so the bench samples it 1 ns after driving the strobes and before the clock edge. Register outputs (`tx_data`, `tone_en`, `cfg_b`) and flag-driven `irq_cp_n` levels are due right after the edge that ends the access or event, and the bench samples them 2 ns after that edge. The call-progress waveform is due SYNC_STAGES edges after `cp_tone` changes, and the bench keeps a shift-register model of that delay. Random cycles mix accesses, events and mode changes, and a few directed sequences cover select-pointer return, burst gating and call-progress masking.

// File: rtl/tthi_pkg.sv
`timescale 1ns/1ps
package tthi_pkg;
   localparam int CTRL_W   = 4;
   // control A fields
   localparam int A_TONE   = 0;
   localparam int A_MODE   = 1;
   localparam int A_IEN    = 2;
   localparam int A_SEL    = 3;
   // control B fields
   localparam int B_BURST  = 0;
   // status fields
   localparam int ST_IRQ   = 0;
   localparam int ST_RXR   = 1;
   localparam int ST_TXR   = 2;
   localparam int ST_DSTR  = 3;

   typedef struct packed {
      logic tx_wr;
      logic rx_rd;
      logic ctl_wr;
      logic st_rd;
   } acc_t;
endpackage

// File: rtl/tthi_decode.sv
`timescale 1ns/1ps
module tthi_decode
   import tthi_pkg::*;
(
   input  logic clk,
   input  logic rst,
   input  logic rs_sel,
   input  logic wr_n,
   input  logic rd_n,
   output acc_t acc
);
   logic wr_act;
   logic rd_act;

   always_comb begin
      wr_act     = !wr_n && rd_n;
      rd_act     = wr_n && !rd_n;
      acc.tx_wr  = wr_act && !rs_sel;
      acc.rx_rd  = rd_act && !rs_sel;
      acc.ctl_wr = wr_act && rs_sel;
      acc.st_rd  = rd_act && rs_sel;
   end

   // R1
   acc_onehot_chk: assert property (@(posedge clk) disable iff (rst)
      $onehot0({acc.tx_wr, acc.rx_rd, acc.ctl_wr, acc.st_rd}));
endmodule

// File: rtl/tthi_ctrl.sv
`timescale 1ns/1ps
module tthi_ctrl
   import tthi_pkg::*;
#(
   parameter int DW = 4
) (
   input  logic          clk,
   input  logic          rst,
   input  logic          ctl_wr,
   input  logic [DW-1:0] din,
   output logic [DW-1:0] cra_q,
   output logic [DW-1:0] crb_q
);
   logic ptr_b;

   always_ff @(posedge clk) begin
      if (rst) begin
         cra_q <= '0;
         crb_q <= '0;
         ptr_b <= 1'b0;
      end else if (ctl_wr) begin
         if (ptr_b) begin
            crb_q <= din;
            ptr_b <= 1'b0;
         end else begin
            cra_q <= din;
            ptr_b <= din[A_SEL];
         end
      end
   end

   // R4
   ptr_return_chk: assert property (@(posedge clk) disable iff (rst)
      (ctl_wr && ptr_b) |=> (!ptr_b && $stable(cra_q)));
   // R4
   b_hold_chk: assert property (@(posedge clk) disable iff (rst)
      (ctl_wr && !ptr_b) |=> $stable(crb_q));
endmodule

// File: rtl/tthi_status.sv
`timescale 1ns/1ps
module tthi_status
   import tthi_pkg::*;
#(
   parameter int DW = 4
) (
   input  logic          clk,
   input  logic          rst,
   input  acc_t          acc,
   input  logic [DW-1:0] din,
   input  logic          cp_mode,
   input  logic          burst_en,
   input  logic          dig_vld,
   input  logic [DW-1:0] dig_code,
   input  logic          tx_req,
   output logic [3:0]    status,
   output logic [DW-1:0] rx_q,
   output logic [DW-1:0] tx_q,
   output logic          irq_flag
);
   logic rx_rdy, tx_rdy, dsteer;
   logic ev_dig, ev_txi;

   always_comb begin
      ev_dig = dig_vld && !cp_mode;
      ev_txi = tx_req && burst_en && !cp_mode;
   end

   always_ff @(posedge clk) begin
      if (rst) begin
         irq_flag <= 1'b0;
         rx_rdy   <= 1'b0;
         tx_rdy   <= 1'b0;
         dsteer   <= 1'b0;
         rx_q     <= '0;
         tx_q     <= '0;
      end else begin
         if (ev_dig || ev_txi)        irq_flag <= 1'b1;
         else if (acc.st_rd)          irq_flag <= 1'b0;
         if (ev_dig)                  rx_rdy <= 1'b1;
         else if (acc.rx_rd)          rx_rdy <= 1'b0;
         if (tx_req)                  tx_rdy <= 1'b1;
         else if (acc.st_rd || acc.tx_wr) tx_rdy <= 1'b0;
         if (ev_dig)                  dsteer <= 1'b1;
         else if (acc.st_rd)          dsteer <= 1'b0;
         if (ev_dig)                  rx_q <= dig_code;
         if (acc.tx_wr)               tx_q <= din;
      end
   end

   always_comb begin
      status          = '0;
      status[ST_IRQ]  = irq_flag;
      status[ST_RXR]  = rx_rdy;
      status[ST_TXR]  = tx_rdy;
      status[ST_DSTR] = dsteer;
   end

   // R5
   stat_clear_chk: assert property (@(posedge clk) disable iff (rst)
      (acc.st_rd && !dig_vld && !tx_req) |=> (!irq_flag && !tx_rdy && !dsteer));
   // R6
   dig_set_chk: assert property (@(posedge clk) disable iff (rst)
      (dig_vld && !cp_mode) |=> (rx_rdy && irq_flag && rx_q == $past(dig_code)));
   // R8
   cp_ignore_chk: assert property (@(posedge clk) disable iff (rst)
      (dig_vld && cp_mode && !acc.rx_rd) |=> ($stable(rx_q) && $stable(rx_rdy)));
   // R7
   tx_clear_chk: assert property (@(posedge clk) disable iff (rst)
      (acc.tx_wr && !tx_req) |=> !tx_rdy);
endmodule

// File: rtl/tthi_irq.sv
`timescale 1ns/1ps
module tthi_irq #(
   parameter int SYNC_STAGES = 2
) (
   input  logic clk,
   input  logic rst,
   input  logic irq_en,
   input  logic cp_mode,
   input  logic irq_flag,
   input  logic cp_tone,
   output logic irq_cp_n
);
   logic cp_s;

   generate
      if (SYNC_STAGES == 0) begin : g_nosync
         assign cp_s = cp_tone;
      end else if (SYNC_STAGES == 1) begin : g_sync1
         logic sh;
         always_ff @(posedge clk) begin
            if (rst) sh <= 1'b0;
            else     sh <= cp_tone;
         end
         assign cp_s = sh;
      end else begin : g_syncn
         logic [SYNC_STAGES-1:0] sh;
         always_ff @(posedge clk) begin
            if (rst) sh <= '0;
            else     sh <= {sh[SYNC_STAGES-2:0], cp_tone};
         end
         assign cp_s = sh[SYNC_STAGES-1];
      end
   endgenerate

   always_comb begin
      if (!irq_en)      irq_cp_n = 1'b1;
      else if (cp_mode) irq_cp_n = cp_s;
      else              irq_cp_n = !irq_flag;
   end
endmodule

// File: rtl/tone_host_regs.sv
`timescale 1ns/1ps
module tone_host_regs
   import tthi_pkg::*;
#(
   parameter int DW          = 4,
   parameter int SYNC_STAGES = 2
) (
   input  logic          clk,
   input  logic          rst,
   input  logic          rs_sel,
   input  logic          wr_n,
   input  logic          rd_n,
   input  logic [DW-1:0] din,
   output logic [DW-1:0] dout,
   input  logic          dig_vld,
   input  logic [DW-1:0] dig_code,
   input  logic          tx_req,
   input  logic          cp_tone,
   output logic [DW-1:0] tx_data,
   output logic          tone_en,
   output logic [DW-1:0] cfg_b,
   output logic          irq_cp_n
);
   generate
      if (DW != CTRL_W) begin : g_bad_dw
         $error("tone_host_regs: DW must equal the control register width");
      end
      if (SYNC_STAGES < 0 || SYNC_STAGES > 4) begin : g_bad_sync
         $error("tone_host_regs: SYNC_STAGES out of range 0..4");
      end
   endgenerate

   acc_t          acc;
   logic [DW-1:0] cra_q, crb_q;
   logic [3:0]    status;
   logic [DW-1:0] rx_q, tx_q;
   logic          irq_flag;

   tthi_decode u_dec (
      .clk(clk), .rst(rst), .rs_sel(rs_sel), .wr_n(wr_n), .rd_n(rd_n), .acc(acc)
   );

   tthi_ctrl #(.DW(DW)) u_ctrl (
      .clk(clk), .rst(rst), .ctl_wr(acc.ctl_wr), .din(din),
      .cra_q(cra_q), .crb_q(crb_q)
   );

   tthi_status #(.DW(DW)) u_stat (
      .clk(clk), .rst(rst), .acc(acc), .din(din),
      .cp_mode(cra_q[A_MODE]), .burst_en(crb_q[B_BURST]),
      .dig_vld(dig_vld), .dig_code(dig_code), .tx_req(tx_req),
      .status(status), .rx_q(rx_q), .tx_q(tx_q), .irq_flag(irq_flag)
   );

   tthi_irq #(.SYNC_STAGES(SYNC_STAGES)) u_irq (
      .clk(clk), .rst(rst), .irq_en(cra_q[A_IEN]), .cp_mode(cra_q[A_MODE]),
      .irq_flag(irq_flag), .cp_tone(cp_tone), .irq_cp_n(irq_cp_n)
   );

   always_comb begin
      if (acc.rx_rd)      dout = rx_q;
      else if (acc.st_rd) dout = status;
      else                dout = '0;
   end

   assign tx_data = tx_q;
   assign tone_en = cra_q[A_TONE];
   assign cfg_b   = crb_q;

   // R9
   ien_off_chk: assert property (@(posedge clk) disable iff (rst)
      (!cra_q[A_IEN] && $stable(cra_q)) |-> irq_cp_n);
   // R10
   reset_state_chk: assert property (@(posedge clk)
      $past(rst) |-> (cra_q == '0 && crb_q == '0 && irq_cp_n && status == '0));
endmodule

// File: tb/tone_host_regs_tb.sv
`timescale 1ns/1ps
module tone_host_regs_tb_top;
   localparam int DW = 4;

   logic clk = 1'b0;
   logic rst = 1'b1;
   logic rs_sel = 1'b0, wr_n = 1'b1, rd_n = 1'b1;
   logic [DW-1:0] din = '0, dig_code = '0;
   logic dig_vld = 1'b0, tx_req = 1'b0, cp_tone = 1'b0;
   logic [DW-1:0] dout, tx_data, cfg_b;
   logic tone_en, irq_cp_n;

   always #4 clk = ~clk;

   tone_host_regs #(.DW(DW), .SYNC_STAGES(2)) dut_i (
      .clk(clk), .rst(rst), .rs_sel(rs_sel), .wr_n(wr_n), .rd_n(rd_n),
      .din(din), .dout(dout), .dig_vld(dig_vld), .dig_code(dig_code),
      .tx_req(tx_req), .cp_tone(cp_tone), .tx_data(tx_data),
      .tone_en(tone_en), .cfg_b(cfg_b), .irq_cp_n(irq_cp_n)
   );

   int n_chk = 0;
   int n_err = 0;
   bit done = 0;

   // model state
   logic [3:0] m_cra, m_crb, m_rx, m_tx;
   logic m_ptr, m_irq, m_rxr, m_txr, m_dst, m_s0, m_s1;

   task automatic chk(input string req, input logic [3:0] act, input logic [3:0] exp);
      n_chk++;
      if (act !== exp) begin
         n_err++;
         $display("FAIL %s actual=%h expected=%h at %0t", req, act, exp, $time);
      end
   endtask

   function automatic logic [3:0] m_status();
      return {m_dst, m_txr, m_rxr, m_irq};
   endfunction

   function automatic logic m_pin();
      if (!m_cra[2]) return 1'b1;
      if (m_cra[1])  return m_s1;
      return !m_irq;
   endfunction

   task automatic m_reset();
      m_cra = 0; m_crb = 0; m_rx = 0; m_tx = 0; m_ptr = 0;
      m_irq = 0; m_rxr = 0; m_txr = 0; m_dst = 0; m_s0 = 0; m_s1 = 0;
   endtask

   task automatic step(input logic rs, input logic wn, input logic rn, input logic [3:0] d,
                       input logic dv, input logic [3:0] dc, input logic tp, input logic cp);
      logic wr, rd, txw, rxr, cw, sr, evd, evt;
      logic [3:0] exp_d;
      @(negedge clk);
      rs_sel = rs; wr_n = wn; rd_n = rn; din = d;
      dig_vld = dv; dig_code = dc; tx_req = tp; cp_tone = cp;
      #1;
      wr = !wn && rn; rd = wn && !rn;
      txw = wr && !rs; rxr = rd && !rs; cw = wr && rs; sr = rd && rs;
      exp_d = rxr ? m_rx : (sr ? m_status() : 4'h0);
      chk(rxr ? "R2 rx read" : (sr ? "R5 status read" : "R1 idle dout"), dout, exp_d);
      evd = dv && !m_cra[1];
      evt = tp && m_crb[0] && !m_cra[1];
      // next state
      if (evd || evt) m_irq = 1; else if (sr) m_irq = 0;
      if (evd) m_rxr = 1; else if (rxr) m_rxr = 0;
      if (tp) m_txr = 1; else if (sr || txw) m_txr = 0;
      if (evd) m_dst = 1; else if (sr) m_dst = 0;
      if (evd) m_rx = dc;
      if (txw) m_tx = d;
      if (cw) begin
         if (m_ptr) begin m_crb = d; m_ptr = 0; end
         else begin m_cra = d; m_ptr = d[3]; end
      end
      m_s1 = m_s0; m_s0 = cp;
      @(posedge clk); #2;
      chk("R1 tx_data", tx_data, m_tx);
      chk("R3 tone_en", {3'b0, tone_en}, {3'b0, m_cra[0]});
      chk("R4 cfg_b", cfg_b, m_crb);
      chk(!m_cra[2] ? "R9 pin idle" : (m_cra[1] ? "R8 cp pin" : "R6 irq pin"),
          {3'b0, irq_cp_n}, {3'b0, m_pin()});
   endtask

   task automatic idle(); step(0, 1, 1, 0, 0, 0, 0, 0); endtask
   task automatic cwr(input logic [3:0] d); step(1, 0, 1, d, 0, 0, 0, 0); endtask

   initial begin
      repeat (2000000) @(posedge clk);
      if (!done) begin
         n_err++; n_chk++;
         $display("FAIL watchdog expired");
         $display("Result: errors=%0d of %0d checks", n_err, n_chk);
         $finish;
      end
   end

   initial begin
      int unsigned seed_v;
      seed_v = $urandom(32'd2024);
      m_reset();
      repeat (3) @(posedge clk);
      @(negedge clk); rst = 1'b0;
      // R10 reset state
      #1;
      chk("R10 tone_en", {3'b0, tone_en}, 4'h0);
      chk("R10 cfg_b", cfg_b, 4'h0);
      chk("R10 pin", {3'b0, irq_cp_n}, 4'h1);
      chk("R10 tx_data", tx_data, 4'h0);
      step(1, 1, 0, 0, 0, 0, 0, 0);   // status read after reset is zero via model

      // R4 pointer sequence
      cwr(4'h8);
      cwr(4'h5);
      chk("R4 b written", cfg_b, 4'h5);
      chk("R4 a kept", {3'b0, tone_en}, 4'h0);
      cwr(4'h1);
      chk("R4 back to a", {3'b0, tone_en}, 4'h1);
      chk("R4 b kept", cfg_b, 4'h5);

      // R1 both strobes low: no write
      step(0, 0, 0, 4'hA, 0, 0, 0, 0);
      chk("R1 both low", tx_data, 4'h0);
      step(0, 0, 1, 4'h9, 0, 0, 0, 0);
      chk("R1 tx write", tx_data, 4'h9);

      // R7 burst gating: ien on, dtmf, burst off
      cwr(4'hC); cwr(4'h0);
      step(0, 1, 1, 0, 0, 0, 1, 0);
      chk("R7 no irq w/o burst", {3'b0, irq_cp_n}, 4'h1);
      step(1, 1, 0, 0, 0, 0, 0, 0);
      cwr(4'hC); cwr(4'h1);
      step(0, 1, 1, 0, 0, 0, 1, 0);
      chk("R7 irq with burst", {3'b0, irq_cp_n}, 4'h0);
      step(1, 1, 0, 0, 0, 0, 0, 0);
      chk("R5 pin released", {3'b0, irq_cp_n}, 4'h1);

      // R6 digit capture and read
      step(0, 1, 1, 0, 1, 4'h7, 0, 0);
      chk("R6 pin low", {3'b0, irq_cp_n}, 4'h0);
      step(0, 1, 0, 0, 0, 0, 0, 0);

      // R8 call-progress mode ignores digits, pin follows tone
      cwr(4'h6);
      step(0, 1, 1, 0, 1, 4'h3, 0, 1);
      step(0, 1, 1, 0, 0, 0, 0, 1);
      chk("R8 pin follows", {3'b0, irq_cp_n}, 4'h1);
      step(0, 1, 0, 0, 0, 0, 0, 0);   // rx read still old code via model
      // R9 ien off
      cwr(4'h2);
      step(0, 1, 1, 0, 0, 0, 0, 0);
      chk("R9 pin high", {3'b0, irq_cp_n}, 4'h1);

      for (int i = 0; i < 3000; i++) begin
         int op;
         logic wn, rn;
         op = $urandom_range(0, 5);
         case (op)
            0, 1: begin wn = 1; rn = 1; end
            2:    begin wn = 0; rn = 1; end
            3, 4: begin wn = 1; rn = 0; end
            default: begin wn = 0; rn = 0; end
         endcase
         step(1'($urandom_range(0, 1)), wn, rn, 4'($urandom_range(0, 15)),
              ($urandom_range(0, 5) == 0), 4'($urandom_range(0, 15)),
              ($urandom_range(0, 5) == 0), 1'($urandom_range(0, 1)));
      end

      done = 1;
      $display("Result: errors=%0d of %0d checks", n_err, n_chk);
      $finish;
   end
endmodule